// File: doc/BRIEF.md
# IRIG-B Time-of-Day Extractor with One-Second Advance

This block sits behind a pulse-width symbol classifier in a time-code receiver. Each classified symbol arrives with its element index within the one-second frame. The block collects the BCD seconds, minutes and hours bits from the front part of the frame. The frame states the second that has just ended, so the block adds one second to the collected time. It then presents the result as a packed BCD time word with a single-cycle strobe.

A symbol at element 0, the reference marker, wipes every captured bit, so nothing from an earlier frame can reach the next result. Once the last hours bit (element 26) has been taken in, the block checks the collected digits. It then issues either a valid strobe with the advanced time or an error strobe. On an error strobe the previously presented time word is left untouched. Day-of-year, control and straight-binary fields are not decoded.

Top module: `irigb_time_extract`

## Requirements
- R1: A symbol is taken only in a cycle with `sym_valid` high. `sym_kind` encodes 2'd0 as a binary zero, 2'd1 as a binary one and 2'd2 as a position marker. Only kind 2'd1 at a field element sets a bit.
- R2: Field elements and weights are as follows. Seconds units are elements 1..4 (weights 1,2,4,8) and seconds tens are elements 6..8 (1,2,4). Minutes units are elements 10..13 and minutes tens are elements 15..17. Hours units are elements 20..23 and hours tens are elements 25..26. Within each digit the lowest weight comes first.
- R3: Symbols at elements 5, 14, 18, 24 and at any element above 26 change neither the captured digits nor the outputs.
- R4: A taken symbol at element 0 clears all captured bits, whatever its kind.
- R5: A symbol at element 26 that is taken at clock edge E produces a one-cycle strobe visible after edge E+1. On `tm_valid` the word `tm_bcd` carries the collected time plus one second. Its layout is [19:18] hours tens, [17:14] hours units, [13:11] minutes tens, [10:7] minutes units, [6:4] seconds tens and [3:0] seconds units.
- R6: Seconds roll from 59 to 00 with a carry into minutes. Minutes roll from 59 to 00 with a carry into hours. A units digit of 9 rolls to 0 and carries into its tens digit.
- R7: Hours roll from 23 to 00.
- R8: The error strobe `tm_err` replaces `tm_valid` and `tm_bcd` is not updated when any of these hold: a units digit above 9, a seconds or minutes tens digit above 5, or hours above 23.
- R9: After reset `tm_valid`, `tm_err` and `tm_bcd` are zero. `tm_bcd` changes only in a cycle with `tm_valid` high.
- R10: `tm_valid` or `tm_err` is high only in the one cycle given by R5, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol present this cycle |
| sym_kind | input | 2 | Symbol class: 0 zero, 1 one, 2 marker |
| sym_pos | input | POS_W (7) | Element index of the symbol in its frame, 0..99 |
| tm_valid | output | 1 | One-cycle strobe: advanced time on tm_bcd |
| tm_err | output | 1 | One-cycle strobe: frame held an invalid digit or field |
| tm_bcd | output | 20 | Packed BCD hours, minutes, seconds |

## Verification
The bench builds the block with the default element-index width of 7 bits, which covers the full 0..99 range of a frame. Complete frames therefore run at their real lengths, with markers at the proper places and set bits in the index and day elements. Between symbols the bench keeps element 26 and a binary one on the bus with the valid line low. This exposes any gating fault. The frames cover every carry chain up to midnight, each class of invalid digit, and a clean frame after a bad one.

// File: rtl/irigb_tx_pkg.sv
package irigb_tx_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_MARK = 2'd2
    } sym_kind_e;

    // Packed so that bit index equals transmission order of the field bits.
    typedef struct packed {
        logic [1:0] ht;
        logic [3:0] hu;
        logic [2:0] mt;
        logic [3:0] mu;
        logic [2:0] st;
        logic [3:0] su;
    } bcd_time_t;

    localparam int TIME_W   = $bits(bcd_time_t);
    localparam int LAST_POS = 26;
    localparam int NUM_SEXA = 2;
    localparam logic [5:0] NO_SLOT = 6'h3F;

    // Element index -> bit index inside bcd_time_t, NO_SLOT when not a field bit.
    function automatic logic [5:0] slot_of(input int unsigned pos);
        if (pos >= 1  && pos <= 4)  return 6'(pos - 1);
        if (pos >= 6  && pos <= 8)  return 6'(pos - 2);
        if (pos >= 10 && pos <= 13) return 6'(pos - 3);
        if (pos >= 15 && pos <= 17) return 6'(pos - 4);
        if (pos >= 20 && pos <= 23) return 6'(pos - 6);
        if (pos >= 25 && pos <= 26) return 6'(pos - 7);
        return NO_SLOT;
    endfunction

endpackage

// File: rtl/irigb_field_capture.sv
module irigb_field_capture
    import irigb_tx_pkg::*;
#(
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [1:0]       sym_kind,
    input  logic [POS_W-1:0] sym_pos,
    output bcd_time_t        fields_o,
    output logic             done_o
);

    typedef struct packed {
        bcd_time_t f;
        logic      done;
    } cap_t;

    cap_t              cap_d, cap_q;
    logic [TIME_W-1:0] bits;
    logic [5:0]        slot;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = 1'b0;
        bits       = cap_q.f;
        slot       = slot_of(int'(sym_pos));
        if (sym_valid) begin
            if (sym_pos == '0) begin
                bits = '0;
            end else if (sym_kind == SYM_ONE && slot < 6'(TIME_W)) begin
                bits[slot[4:0]] = 1'b1;
            end
            if (sym_pos == POS_W'(LAST_POS)) begin
                cap_d.done = 1'b1;
            end
        end
        cap_d.f = bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign fields_o = cap_q.f;
    assign done_o   = cap_q.done;

endmodule

// File: rtl/irigb_sexa_step.sv
module irigb_sexa_step (
    input  logic [2:0] tens_i,
    input  logic [3:0] units_i,
    input  logic       cin,
    output logic [2:0] tens_o,
    output logic [3:0] units_o,
    output logic       cout,
    output logic       bad
);

    always_comb begin
        tens_o  = tens_i;
        units_o = units_i;
        cout    = 1'b0;
        bad     = (units_i > 4'd9) || (tens_i > 3'd5);
        if (cin) begin
            if (units_i == 4'd9) begin
                units_o = 4'd0;
                if (tens_i == 3'd5) begin
                    tens_o = 3'd0;
                    cout   = 1'b1;
                end else begin
                    tens_o = tens_i + 3'd1;
                end
            end else begin
                units_o = units_i + 4'd1;
            end
        end
    end

endmodule

// File: rtl/irigb_time_incr.sv
module irigb_time_incr
    import irigb_tx_pkg::*;
(
    input  bcd_time_t cur_i,
    output bcd_time_t nxt_o,
    output logic      bad_o
);

    logic [2:0] t_in  [NUM_SEXA];
    logic [3:0] u_in  [NUM_SEXA];
    logic [2:0] t_out [NUM_SEXA];
    logic [3:0] u_out [NUM_SEXA];
    logic       carry [NUM_SEXA+1];
    logic       sbad  [NUM_SEXA];
    logic       hr_bad;

    assign t_in[0]  = cur_i.st;
    assign u_in[0]  = cur_i.su;
    assign t_in[1]  = cur_i.mt;
    assign u_in[1]  = cur_i.mu;
    assign carry[0] = 1'b1;

    for (genvar g = 0; g < NUM_SEXA; g++) begin : g_sexa
        irigb_sexa_step u_step (
            .tens_i  (t_in[g]),
            .units_i (u_in[g]),
            .cin     (carry[g]),
            .tens_o  (t_out[g]),
            .units_o (u_out[g]),
            .cout    (carry[g+1]),
            .bad     (sbad[g])
        );
    end

    always_comb begin
        nxt_o.su = u_out[0];
        nxt_o.st = t_out[0];
        nxt_o.mu = u_out[1];
        nxt_o.mt = t_out[1];
        nxt_o.hu = cur_i.hu;
        nxt_o.ht = cur_i.ht;
        hr_bad   = (cur_i.hu > 4'd9) || (cur_i.ht > 2'd2) ||
                   (cur_i.ht == 2'd2 && cur_i.hu > 4'd3);
        if (carry[NUM_SEXA]) begin
            if (cur_i.ht == 2'd2 && cur_i.hu == 4'd3) begin
                nxt_o.hu = 4'd0;
                nxt_o.ht = 2'd0;
            end else if (cur_i.hu == 4'd9) begin
                nxt_o.hu = 4'd0;
                nxt_o.ht = cur_i.ht + 2'd1;
            end else begin
                nxt_o.hu = cur_i.hu + 4'd1;
            end
        end
        bad_o = sbad[0] || sbad[1] || hr_bad;
    end

endmodule

// File: rtl/irigb_time_extract.sv
module irigb_time_extract
    import irigb_tx_pkg::*;
#(
    parameter int POS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic [1:0]        sym_kind,
    input  logic [POS_W-1:0]  sym_pos,
    output logic              tm_valid,
    output logic              tm_err,
    output logic [TIME_W-1:0] tm_bcd
);

    typedef struct packed {
        bcd_time_t t;
        logic      v;
        logic      e;
    } out_t;

    bcd_time_t fields;
    bcd_time_t advanced;
    logic      done;
    logic      bad;
    out_t      out_d, out_q;

    irigb_field_capture #(.POS_W(POS_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_kind  (sym_kind),
        .sym_pos   (sym_pos),
        .fields_o  (fields),
        .done_o    (done)
    );

    irigb_time_incr u_incr (
        .cur_i (fields),
        .nxt_o (advanced),
        .bad_o (bad)
    );

    always_comb begin
        out_d   = out_q;
        out_d.v = 1'b0;
        out_d.e = 1'b0;
        if (done) begin
            if (bad) begin
                out_d.e = 1'b1;
            end else begin
                out_d.v = 1'b1;
                out_d.t = advanced;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tm_valid = out_q.v;
    assign tm_err   = out_q.e;
    assign tm_bcd   = out_q.t;

endmodule

// File: rtl/irigb_time_extract_chk.sv
module irigb_time_extract_chk
    import irigb_tx_pkg::*;
#(
    parameter int POS_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_valid,
    input logic [POS_W-1:0]  sym_pos,
    input logic              tm_valid,
    input logic              tm_err,
    input logic [TIME_W-1:0] tm_bcd
);

    logic last_sym;
    assign last_sym = sym_valid && (sym_pos == POS_W'(LAST_POS));

    a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(tm_valid && tm_err));

    a_r10_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_valid || tm_err) |-> $past(last_sym, 2));

    a_r5_strobe_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_sym |-> ##2 (tm_valid || tm_err));

    a_r9_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tm_valid |-> $stable(tm_bcd));

    a_r6_digits_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tm_valid |-> (tm_bcd[3:0] <= 4'd9 && tm_bcd[6:4] <= 3'd5 &&
                      tm_bcd[10:7] <= 4'd9 && tm_bcd[13:11] <= 3'd5));

    a_r7_hours_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tm_valid |-> (tm_bcd[17:14] <= 4'd9 &&
                      {tm_bcd[19:18], tm_bcd[17:14]} <= 6'h23));

endmodule

bind irigb_time_extract irigb_time_extract_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_pos   (sym_pos),
    .tm_valid  (tm_valid),
    .tm_err    (tm_err),
    .tm_bcd    (tm_bcd)
);

// File: tb/irigb_time_extract_test.sv
`timescale 1ns/1ps
module irigb_time_extract_test;

    localparam int POS_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sym_valid;
    logic [1:0]       sym_kind;
    logic [POS_W-1:0] sym_pos;
    logic             tm_valid;
    logic             tm_err;
    logic [19:0]      tm_bcd;

    int vectors = 0;
    int miscompares = 0;
    bit run_done = 1'b0;

    int m_su, m_st, m_mu, m_mt, m_hu, m_ht;
    logic        exp_v, exp_e, pend_v, pend_e;
    logic [19:0] exp_t, pend_t;

    always #2 clk = ~clk;

    irigb_time_extract #(.POS_W(POS_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_kind  (sym_kind),
        .sym_pos   (sym_pos),
        .tm_valid  (tm_valid),
        .tm_err    (tm_err),
        .tm_bcd    (tm_bcd)
    );

    function automatic logic [19:0] pack_time(input int h, input int m, input int s);
        return {2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(s / 10), 4'(s % 10)};
    endfunction

    // Behavioural reference: digit accumulators plus a one-stage result slot.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v = 0; exp_e = 0; exp_t = '0;
            pend_v = 0; pend_e = 0; pend_t = '0;
            m_su = 0; m_st = 0; m_mu = 0; m_mt = 0; m_hu = 0; m_ht = 0;
        end else begin
            exp_v = pend_v;
            exp_e = pend_e;
            if (pend_v) exp_t = pend_t;
            pend_v = 0;
            pend_e = 0;
            if (sym_valid) begin
                int p;
                p = int'(sym_pos);
                if (p == 0) begin
                    m_su = 0; m_st = 0; m_mu = 0; m_mt = 0; m_hu = 0; m_ht = 0;
                end else if (sym_kind == 2'd1) begin
                    if (p >= 1 && p <= 4)   m_su += 1 << (p - 1);
                    if (p >= 6 && p <= 8)   m_st += 1 << (p - 6);
                    if (p >= 10 && p <= 13) m_mu += 1 << (p - 10);
                    if (p >= 15 && p <= 17) m_mt += 1 << (p - 15);
                    if (p >= 20 && p <= 23) m_hu += 1 << (p - 20);
                    if (p >= 25 && p <= 26) m_ht += 1 << (p - 25);
                end
                if (p == 26) begin
                    if (m_su > 9 || m_st > 5 || m_mu > 9 || m_mt > 5 || m_hu > 9 ||
                        (m_ht * 10 + m_hu) > 23) begin
                        pend_e = 1;
                    end else begin
                        int tot;
                        tot = ((m_ht * 10 + m_hu) * 3600 + (m_mt * 10 + m_mu) * 60 +
                               m_st * 10 + m_su + 1) % 86400;
                        pend_t = pack_time(tot / 3600, (tot / 60) % 60, tot % 60);
                        pend_v = 1;
                    end
                end
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !run_done) begin
            vectors++;
            if (tm_valid !== exp_v) begin
                miscompares++;
                $display("FAIL R5/R10 strobe: tm_valid=%0b expected %0b at %0t", tm_valid, exp_v, $time);
            end
            if (tm_err !== exp_e) begin
                miscompares++;
                $display("FAIL R8 error strobe: tm_err=%0b expected %0b at %0t", tm_err, exp_e, $time);
            end
            if (tm_bcd !== exp_t) begin
                miscompares++;
                $display("FAIL R5/R6/R7/R9 time word: tm_bcd=%05h expected %05h at %0t", tm_bcd, exp_t, $time);
            end
        end
    end

    task automatic idle_bus();
        // R1: a plausible last-element one held with valid low must be ignored
        sym_valid = 1'b0;
        sym_kind  = 2'd1;
        sym_pos   = POS_W'(26);
    endtask

    task automatic send_sym(input logic [1:0] kind, input int pos);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_kind  = kind;
        sym_pos   = POS_W'(pos);
        @(negedge clk);
        idle_bus();
    endtask

    function automatic int field_bit(input int p, input int su, input int st, input int mu,
                                     input int mt, input int hu, input int ht);
        if (p >= 1 && p <= 4)   return (su >> (p - 1)) & 1;
        if (p >= 6 && p <= 8)   return (st >> (p - 6)) & 1;
        if (p >= 10 && p <= 13) return (mu >> (p - 10)) & 1;
        if (p >= 15 && p <= 17) return (mt >> (p - 15)) & 1;
        if (p >= 20 && p <= 23) return (hu >> (p - 20)) & 1;
        if (p >= 25 && p <= 26) return (ht >> (p - 25)) & 1;
        return 0;
    endfunction

    task automatic send_frame(input int su, input int st, input int mu, input int mt,
                              input int hu, input int ht, input bit noise);
        for (int p = 0; p < 100; p++) begin
            logic [1:0] k;
            if (p == 0 || p % 10 == 9) k = 2'd2;
            else if (noise && (p == 5 || p == 14 || p == 18 || p == 24 || p == 27 || p == 28 || p == 40))
                k = 2'd1; // R3: index and day elements carry ones
            else k = field_bit(p, su, st, mu, mt, hu, ht) != 0 ? 2'd1 : 2'd0;
            send_sym(k, p);
        end
    endtask

    task automatic send_hms(input int h, input int m, input int s, input bit noise);
        send_frame(s % 10, s / 10, m % 10, m / 10, h % 10, h / 10, noise);
    endtask

    initial begin
        rst_n = 1'b0;
        idle_bus();
        repeat (4) @(negedge clk);
        // R9: reset state
        vectors++;
        if (tm_valid !== 1'b0 || tm_err !== 1'b0 || tm_bcd !== 20'h0) begin
            miscompares++;
            $display("FAIL R9 reset: valid=%0b err=%0b bcd=%05h expected 0 0 00000", tm_valid, tm_err, tm_bcd);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        send_hms(12, 34, 56, 0); // R2 R5: plain advance to 12:34:57
        send_hms(9, 9, 9, 0);    // R6: units 9 carries into tens
        send_hms(0, 0, 59, 1);   // R3 R6: seconds carry, index bits set
        send_hms(0, 59, 59, 0);  // R6: minutes carry into hours
        send_hms(19, 59, 59, 0); // R6: hours units 9 carries into tens
        send_hms(23, 59, 59, 1); // R7: midnight rollover
        send_frame(10, 0, 0, 0, 0, 0, 0); // R8: seconds units above 9
        send_frame(0, 0, 0, 6, 0, 0, 0);  // R8: minutes tens above 5
        send_frame(0, 6, 0, 0, 0, 0, 0);  // R8: seconds tens above 5
        send_frame(4, 0, 0, 0, 4, 2, 0);  // R8: hours 24
        send_frame(0, 0, 12, 0, 0, 0, 0); // R8: minutes units above 9
        send_hms(0, 0, 0, 0);    // R4: clean frame after bad frames gives 00:00:01
        send_hms(5, 27, 38, 1);  // R1 R2: mixed bit pattern
        repeat (6) @(negedge clk);
        run_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #800000;
        if (!run_done) begin
            run_done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run not complete, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule